// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Controller

This block sits between a register bus and the serial shifters of a UART. It holds a transmit FIFO and a receive FIFO, 16 bytes each by default. Software pushes bytes for transmission by writing the data register and pops received bytes by reading it. On the serial side, bytes go to the transmit shifter and come from the receive shifter over valid/ready handshakes. Each direction has its own enable in the control register.

Each direction raises an interrupt request from its FIFO fill level. The receive side uses a programmable threshold of level field + 1. The transmit side uses a fixed threshold of 8 entries or fewer. A request becomes pending only on the cycle the fill level *crosses* into its threshold region, never merely because the level already sits there. Two-state crossing trackers detect this. They have the states `LVL_OUT` (condition false) and `LVL_IN` (condition true). The transition `LVL_OUT -> LVL_IN` emits a one-cycle hit, and `LVL_IN -> LVL_OUT` re-arms the tracker. The transmit tracker leaves reset in `LVL_IN`, because an empty FIFO already meets its condition. The receive tracker leaves reset in `LVL_OUT`. Since crossings alone raise requests, software that re-enables transmit interrupts uses the force bits to set a pending flag by hand.

Register map, with 3-bit addresses:
- 0 is the data register: a write pushes to TX and a read pops from RX.
- 1 is the control register.
- 2 is the FIFO configuration register.
- 3 is the interrupt enable register.
- 4 is the interrupt pending, acknowledge and force register.
- 5 is the state register (read only).

Top module: `uart_queue_irq`

## Requirements
- R1: After reset, the state register reads 0x0E while the tx_idle input is high, both irq outputs are low, and the control, interrupt-enable and pending registers read 0.
- R2: Control bit 0 gates tx_valid and control bit 1 gates rx_ready; writing 0 to the control register stops both directions.
- R3: A data-register write pushes one byte into the TX FIFO, and bytes leave on tx_data in write order, one per tx_valid&&tx_ready cycle; a write to a full TX FIFO is ignored.
- R4: A data-register read returns and pops the oldest RX byte; reading an empty RX FIFO returns 0 and changes nothing; rx_ready is low while the RX FIFO is full.
- R5: RX pending (pending-register bit 1) sets when the RX level rises to the threshold field + 1, where the field is configuration bits [3:2]; the default field 0 fires on the first byte.
- R6: TX pending (pending-register bit 0) sets when the TX level falls from above 8 to 8 or fewer, including by a FIFO clear.
- R7: No pending flag is set again while the level stays inside its threshold region; it fires again only after the level leaves the region and re-enters it.
- R8: irq_tx and irq_rx equal their pending flag ANDed with interrupt-enable bit 0 (TX) or bit 1 (RX); a pending flag is kept while its enable is off.
- R9: Writing 1 to pending-register bit 0 or bit 1 clears the TX or RX pending flag; writing 0 leaves it unchanged.
- R10: Writing 1 to pending-register bit 4 or bit 5 sets the TX or RX pending flag whatever the level; force and a crossing both take priority over an acknowledge in the same write.
- R11: Configuration bit 0 empties the RX FIFO and bit 1 empties the TX FIFO, each without touching the other; both bits read back as 0.
- R12: State bits are: 0 TX full, 1 TX empty, 2 tx_idle input, 3 RX empty, 4 transmit in progress (TX not empty and tx_idle low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at data address) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the strobe cycle |
| tx_valid | output | 1 | TX byte available to the shifter |
| tx_data | output | 8 | Oldest TX byte |
| tx_ready | input | 1 | Shifter takes the TX byte |
| tx_idle | input | 1 | Transmit shifter idle |
| rx_valid | input | 1 | Shifter offers an RX byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | RX FIFO accepts the byte |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is a second crossing of the same threshold. The tracker has to leave `LVL_IN` before a new pending flag can appear. The bench acknowledges a flag while the level still sits inside the region and pushes further bytes to show that nothing re-fires. It then drains the FIFO below the threshold and refills it to show the flag returns. For transmit, the crossing is reached by filling the FIFO with the transmitter disabled, then releasing bytes one at a time through tx_ready. A FIFO clear from above the threshold serves as a second way to produce a crossing.

// File: rtl/uqi_pkg.sv
`timescale 1ns/1ps
package uqi_pkg;
    localparam int RW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] ADR_DATA = 3'd0;
    localparam logic [AW-1:0] ADR_CTRL = 3'd1;
    localparam logic [AW-1:0] ADR_FCFG = 3'd2;
    localparam logic [AW-1:0] ADR_IEN  = 3'd3;
    localparam logic [AW-1:0] ADR_IST  = 3'd4;
    localparam logic [AW-1:0] ADR_STAT = 3'd5;

    typedef enum logic {
        LVL_OUT = 1'b0,
        LVL_IN  = 1'b1
    } lvl_state_e;

    typedef struct packed {
        logic tx_busy;
        logic rx_empty;
        logic tx_idle;
        logic tx_empty;
        logic tx_full;
    } stat_t;
endpackage

// File: rtl/uqi_fifo.sv
`timescale 1ns/1ps
module uqi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign level   = count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty);
    a_r11_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/uqi_cross.sv
`timescale 1ns/1ps
module uqi_cross
    import uqi_pkg::*;
#(
    parameter bit RESET_IN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    lvl_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RESET_IN ? LVL_IN : LVL_OUT;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        hit     = 1'b0;
        unique case (state)
            LVL_OUT: if (cond) begin
                state_n = LVL_IN;
                hit     = 1'b1;
            end
            LVL_IN:  if (!cond) state_n = LVL_OUT;
        endcase
    end

    a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/uart_queue_irq.sv
`timescale 1ns/1ps
module uart_queue_irq
    import uqi_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TX_THR = 8,
    parameter int LVLW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          tx_valid,
    output logic [RW-1:0] tx_data,
    input  logic          tx_ready,
    input  logic          tx_idle,
    input  logic          rx_valid,
    input  logic [RW-1:0] rx_data,
    output logic          rx_ready,
    output logic          irq_tx,
    output logic          irq_rx
);
    localparam int CW     = $clog2(DEPTH) + 1;
    localparam int LVL_LO = 2;
    localparam int LVL_HI = LVL_LO + LVLW - 1;

    logic            ctrl_tx_en, ctrl_rx_en;
    logic [LVLW-1:0] rx_lvl;
    logic            ie_tx, ie_rx;
    logic            pend_tx, pend_rx;

    logic wr_data, wr_ctrl, wr_fcfg, wr_ien, wr_ist, rd_data;
    logic clr_rx, clr_tx;
    logic tx_push, tx_pop, rx_push, rx_pop;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] tx_level, rx_level, rx_thr;
    logic [RW-1:0] rx_head;
    logic tx_hit, rx_hit;
    stat_t stat;

    assign wr_data = reg_wr && (reg_addr == ADR_DATA);
    assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_fcfg = reg_wr && (reg_addr == ADR_FCFG);
    assign wr_ien  = reg_wr && (reg_addr == ADR_IEN);
    assign wr_ist  = reg_wr && (reg_addr == ADR_IST);
    assign rd_data = reg_rd && (reg_addr == ADR_DATA);

    assign clr_rx  = wr_fcfg && reg_wdata[0];
    assign clr_tx  = wr_fcfg && reg_wdata[1];

    assign tx_push  = wr_data;
    assign tx_valid = ctrl_tx_en && !tx_empty;
    assign tx_pop   = tx_valid && tx_ready;
    assign rx_ready = ctrl_rx_en && !rx_full;
    assign rx_push  = rx_valid && rx_ready;
    assign rx_pop   = rd_data;

    uqi_fifo #(.W(RW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx),
        .push(tx_push), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    uqi_fifo #(.W(RW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx),
        .push(rx_push), .wdata(rx_data),
        .pop(rx_pop), .rdata(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    assign rx_thr = CW'(rx_lvl) + CW'(1);

    uqi_cross #(.RESET_IN(1'b1)) u_txx (
        .clk(clk), .rst_n(rst_n),
        .cond(tx_level <= CW'(TX_THR)), .hit(tx_hit)
    );

    uqi_cross #(.RESET_IN(1'b0)) u_rxx (
        .clk(clk), .rst_n(rst_n),
        .cond(rx_level >= rx_thr), .hit(rx_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_tx_en <= 1'b0;
            ctrl_rx_en <= 1'b0;
            rx_lvl     <= '0;
            ie_tx      <= 1'b0;
            ie_rx      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_tx_en <= reg_wdata[0];
                ctrl_rx_en <= reg_wdata[1];
            end
            if (wr_fcfg) rx_lvl <= reg_wdata[LVL_HI:LVL_LO];
            if (wr_ien) begin
                ie_tx <= reg_wdata[0];
                ie_rx <= reg_wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_tx <= 1'b0;
            pend_rx <= 1'b0;
        end else begin
            if ((wr_ist && reg_wdata[4]) || tx_hit) pend_tx <= 1'b1;
            else if (wr_ist && reg_wdata[0])        pend_tx <= 1'b0;
            if ((wr_ist && reg_wdata[5]) || rx_hit) pend_rx <= 1'b1;
            else if (wr_ist && reg_wdata[1])        pend_rx <= 1'b0;
        end
    end

    assign irq_tx = pend_tx && ie_tx;
    assign irq_rx = pend_rx && ie_rx;

    always_comb begin
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.tx_idle  = tx_idle;
        stat.rx_empty = rx_empty;
        stat.tx_busy  = !(tx_empty || tx_idle);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_DATA: reg_rdata = rx_empty ? '0 : rx_head;
            ADR_CTRL: reg_rdata = {6'd0, ctrl_rx_en, ctrl_tx_en};
            ADR_FCFG: reg_rdata[LVL_HI:LVL_LO] = rx_lvl;
            ADR_IEN:  reg_rdata = {6'd0, ie_rx, ie_tx};
            ADR_IST:  reg_rdata = {6'd0, pend_rx, pend_tx};
            ADR_STAT: reg_rdata = {3'd0, stat};
            default:  reg_rdata = '0;
        endcase
    end

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ist && reg_wdata[1] && !reg_wdata[5] && !rx_hit) |=> !pend_rx);
    a_r6_tx_hit_pends: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> pend_tx);
    a_r2_no_push_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rx_en && !clr_rx && !rx_pop) |=> $stable(rx_level));
endmodule

// File: tb/tb_uart_queue_irq.sv
`timescale 1ns/1ps
module tb_uart_queue_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_valid, tx_ready = 1'b0, tx_idle = 1'b1;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic       irq_tx, irq_rx;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_queue_irq dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_idle(tx_idle), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_send(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] b, output logic v);
        @(negedge clk);
        tx_ready = 1'b1;
        #1 b = tx_data; v = tx_valid;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd5, d); chk("R1 state", d, 8'h0E);
        chk("R1 irq_tx", irq_tx, 0);
        chk("R1 irq_rx", irq_rx, 0);
        rd(3'd1, d); chk("R1 ctrl", d, 0);
        rd(3'd3, d); chk("R1 ien", d, 0);
        rd(3'd4, d); chk("R1 pend", d, 0);
    endtask

    task automatic t_rx_default();
        logic [7:0] d;
        wr(3'd1, 8'h02); wr(3'd3, 8'h02);
        rx_send(8'hA1); idle();
        chk("R5 first byte fires", irq_rx, 1);
        rx_send(8'hA2);
        wr(3'd4, 8'h02);
        rd(3'd4, d); chk("R9 ack rx", d, 0);
        rx_send(8'hA3); idle();
        chk("R7 no refire inside", irq_rx, 0);
        rd(3'd0, d); chk("R4 order 1", d, 8'hA1);
        rd(3'd0, d); chk("R4 order 2", d, 8'hA2);
        rd(3'd0, d); chk("R4 order 3", d, 8'hA3);
        rd(3'd0, d); chk("R4 empty read zero", d, 0);
        rd(3'd5, d); chk("R12 rx empty", d[3], 1);
        rx_send(8'hB0); idle();
        chk("R7 refire after leaving", irq_rx, 1);
        wr(3'd4, 8'h02);
        rd(3'd0, d); chk("R4 empty read no effect", d, 8'hB0);
    endtask

    task automatic t_rx_level();
        logic [7:0] d;
        wr(3'd2, 8'h0C);
        for (int i = 0; i < 3; i++) rx_send(8'(8'h10 + i));
        idle(); chk("R5 below lvl3", irq_rx, 0);
        rx_send(8'h13); idle();
        chk("R5 fires at four", irq_rx, 1);
        rd(3'd2, d); chk("R11 cfg readback", d, 8'h0C);
        wr(3'd4, 8'h02);
        wr(3'd2, 8'h0D);
        rd(3'd5, d); chk("R11 rx cleared", d[3], 1);
        rd(3'd0, d); chk("R11 cleared data", d, 0);
        rd(3'd2, d); chk("R11 self clear", d, 8'h0C);
    endtask

    task automatic t_rx_full();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) rx_send(8'(i));
        #1 chk("R4 rx_ready low full", rx_ready, 0);
        rd(3'd0, d); chk("R4 head after full", d, 0);
        #1 chk("R4 rx_ready after pop", rx_ready, 1);
        wr(3'd2, 8'h0D); wr(3'd4, 8'h02);
        wr(3'd1, 8'h00);
        #1 chk("R2 rx off", rx_ready, 0);
        rx_send(8'h77);
        rd(3'd5, d); chk("R2 rx off no push", d[3], 1);
    endtask

    task automatic t_tx();
        logic [7:0] d; logic v;
        for (int i = 0; i < 17; i++) wr(3'd0, 8'(8'h40 + i));
        rd(3'd5, d); chk("R3 tx full", d[0], 1);
        chk("R2 tx off", tx_valid, 0);
        wr(3'd3, 8'h01);
        tx_idle = 1'b0;
        wr(3'd1, 8'h01);
        chk("R2 tx on", tx_valid, 1);
        rd(3'd5, d); chk("R12 state busy", d, 8'h19);
        for (int i = 0; i < 7; i++) begin
            tx_take(d, v); chk("R3 tx order", d, 8'h40 + i);
        end
        idle(); chk("R6 nine left quiet", irq_tx, 0);
        tx_take(d, v); idle();
        chk("R6 fires at eight", irq_tx, 1);
        wr(3'd4, 8'h01);
        for (int i = 8; i < 16; i++) begin
            tx_take(d, v); chk("R3 tx order late", d, 8'h40 + i);
        end
        chk("R3 17th ignored", tx_valid, 0);
        chk("R7 no tx refire", irq_tx, 0);
        rd(3'd5, d); chk("R12 state empty", d, 8'h0A);
        tx_idle = 1'b1;
    endtask

    task automatic t_force();
        logic [7:0] d;
        wr(3'd4, 8'h10); chk("R10 force tx", irq_tx, 1);
        wr(3'd4, 8'h11); chk("R10 force beats ack", irq_tx, 1);
        wr(3'd4, 8'h01); chk("R9 ack tx", irq_tx, 0);
        wr(3'd4, 8'h20); wr(3'd4, 8'h00);
        rd(3'd4, d); chk("R9 write zero no effect", d, 8'h02);
        wr(3'd3, 8'h00);
        chk("R8 gated off", irq_rx, 0);
        rd(3'd4, d); chk("R8 pend kept", d, 8'h02);
        wr(3'd3, 8'h02); chk("R8 gated on", irq_rx, 1);
        wr(3'd4, 8'h02);
    endtask

    task automatic t_tx_clear();
        logic [7:0] d;
        wr(3'd1, 8'h02); wr(3'd2, 8'h00);
        rx_send(8'h55); rx_send(8'h66);
        wr(3'd4, 8'h03);
        for (int i = 0; i < 12; i++) wr(3'd0, 8'(i));
        wr(3'd2, 8'h02); idle();
        rd(3'd5, d);
        chk("R11 tx cleared", d[1], 1);
        chk("R11 rx untouched", d[3], 0);
        rd(3'd4, d); chk("R6 clear crossing", d[0], 1);
        rd(3'd0, d); chk("R11 rx data kept", d, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rx_default();
        t_rx_level();
        t_rx_full();
        t_tx();
        t_force();
        t_tx_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule